// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block merges the interrupt sources of a 16550-style serial port into a single interrupt request and an 8-bit identification byte that software reads to learn why the port interrupted. There are five sources: receive line errors, received data at or above a threshold, receive timeout, transmitter empty and modem-line changes. Each source has its own enable bit. When several sources are active at once, the byte reports the most urgent enabled one.

Receive line errors and receive timeouts are latched inside the block. Each stays latched until the surrounding register logic issues the matching clear strobe. The transmitter-empty source is armed each time the transmitter becomes empty, and it is disarmed when software reads an identification byte that reports it. Received data and modem changes are level conditions taken directly from the inputs. The receive threshold depends on the FIFO-mode flag and on a 2-bit trigger selection.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with every enable bit clear, the identification byte reads 0x01 and the interrupt output is low.
- R2: Bit 0 of the identification byte is 0 exactly when some enabled source is active, and 1 otherwise. The interrupt output is high exactly when bit 0 is 0. Bits 5:4 always read 0.
- R3: Bits 7:6 of the identification byte read 11 while the FIFO-mode flag is set, and 00 while it is clear.
- R4: In FIFO mode, the trigger selection maps 0 to 1 entry, 1 to 4 entries, 2 to 8 entries and 3 to 15 entries. The received-data source is active while the receive level is at or above that threshold, and it reports code 2 in bits 3:1.
- R5: With the FIFO-mode flag clear, the threshold is 1 entry whatever the trigger selection.
- R6: Any line-error flag latches the line source from the next clock edge. The line source reports code 3. It holds until a line clear strobe, and a new error in the same cycle as the clear keeps it latched.
- R7: A receive-timeout pulse latches the timeout source from the next clock edge. The timeout source reports code 6 and holds until the timeout clear strobe.
- R8: The transmit source reports code 1 while it is armed and the transmitter is empty. It is armed at reset and on every rising edge of the transmitter-empty input. An identification read that returns code 1 with bit 0 low disarms it from the next edge. A read that returns any other code leaves it armed.
- R9: Any modem delta flag makes the modem source active, which reports code 0 in bits 3:1.
- R10: Among enabled active sources, priority runs from line status, then received data, then timeout, then transmit empty, then modem status.
- R11: Enable bit 0 gates received data, bit 1 transmit empty, bit 2 line status, bit 3 modem status and bit 4 timeout. A source whose enable bit is clear affects neither the interrupt output nor the identification byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enMask | input | 5 | Per-source enable bits |
| fifoOn | input | 1 | FIFO mode active |
| trigSel | input | 2 | Receive trigger selection |
| rxLevel | input | LEVEL_W (5) | Current receive FIFO occupancy |
| lineErr | input | LINE_W (4) | Receive error flags (overrun, parity, framing, break) |
| lineClr | input | 1 | Clear strobe for the latched line source |
| rxTimeout | input | 1 | Receive timeout pulse |
| timeoutClr | input | 1 | Clear strobe for the latched timeout source |
| txEmpty | input | 1 | Transmitter holding side is empty |
| modemDelta | input | MODEM_W (4) | Modem-line change flags |
| identRd | input | 1 | Strobe marking a read of the identification byte |
| irq | output | 1 | Interrupt request |
| identVal | output | 8 | Identification byte |

## Verification
Enables, the FIFO-mode flag, the trigger selection, the receive level, the modem flags and the transmitter-empty level reach the outputs combinationally, in the same cycle. The bench therefore checks them one time step after driving them, with no clock edge in between. Line errors, timeout pulses, clear strobes, identification reads and transmitter-empty rising edges act only at the following clock edge. For these, the bench drives the input just after an edge, lets exactly one edge pass, and then samples. The enable and threshold sweeps reuse latched state that was set up this way, so every combination is checked against a state whose timing is already known.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Source codes reported in bits 3:1 of the identification byte
  typedef enum logic [2:0] {
    SRC_MODEM = 3'd0,
    SRC_TXE   = 3'd1,
    SRC_RXD   = 3'd2,
    SRC_LINE  = 3'd3,
    SRC_RXTO  = 3'd6
  } srcCode_e;

  // Enable bit positions
  localparam int EN_RXD   = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_RXTO  = 4;
  localparam int EN_W     = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic setLine;
    logic clrLine;
    logic setTo;
    logic clrTo;
    logic armTx;
    logic clrTx;
  } irqStrobe_t;

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int LINE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINE_W-1:0] lineErr,
  input  logic              lineClr,
  input  logic              rxTimeout,
  input  logic              timeoutClr,
  input  logic              txEmpty,
  input  logic              identRd,
  input  srcCode_e          curCode,
  input  logic              curPending,
  output irqStrobe_t        strobe
);

  logic txPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txPrev <= 1'b0;
    else       txPrev <= txEmpty;
  end

  always_comb begin
    strobe.setLine = |lineErr;
    strobe.clrLine = lineClr;
    strobe.setTo   = rxTimeout;
    strobe.clrTo   = timeoutClr;
    strobe.armTx   = txEmpty & ~txPrev;
    // Disarm only when the value read actually reported the transmit source
    strobe.clrTx   = identRd & curPending & (curCode == SRC_TXE);
  end

  // R8: a new empty edge always arms the transmit source
  p_tx_edge_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> strobe.armTx);

endmodule

// File: rtl/uart_irq_dpath.sv
module uart_irq_dpath
  import uart_irq_pkg::*;
#(
  parameter int LEVEL_W = 5,
  parameter int MODEM_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [EN_W-1:0]    enMask,
  input  logic               fifoOn,
  input  logic [1:0]         trigSel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               txEmpty,
  input  logic [MODEM_W-1:0] modemDelta,
  output logic               irq,
  output logic [7:0]         identVal,
  output srcCode_e           curCode,
  output logic               curPending
);

  localparam int N_STICKY = 2;   // index 0: line status, 1: timeout

  logic [N_STICKY-1:0] stickySet, stickyClr, stickyQ;
  logic                txArm;
  logic [LEVEL_W-1:0]  rxThresh;
  logic [EN_W-1:0]     srcActive, srcLive;
  logic                lineFlag, toFlag;

  assign stickySet = {strobe.setTo, strobe.setLine};
  assign stickyClr = {strobe.clrTo, strobe.clrLine};

  // Latched sources: a set in the same cycle as a clear wins
  for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[i] <= 1'b0;
      else       stickyQ[i] <= stickySet[i] | (stickyQ[i] & ~stickyClr[i]);
    end
  end

  assign lineFlag = stickyQ[0];
  assign toFlag   = stickyQ[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txArm <= 1'b1;
    else       txArm <= strobe.armTx | (txArm & ~strobe.clrTx);
  end

  // Receive threshold
  always_comb begin
    if (!fifoOn) rxThresh = LEVEL_W'(1);
    else begin
      case (trigSel)
        2'd0:    rxThresh = LEVEL_W'(1);
        2'd1:    rxThresh = LEVEL_W'(4);
        2'd2:    rxThresh = LEVEL_W'(8);
        default: rxThresh = LEVEL_W'(15);
      endcase
    end
  end

  always_comb begin
    srcActive           = '0;
    srcActive[EN_RXD]   = rxLevel >= rxThresh;
    srcActive[EN_TXE]   = txArm & txEmpty;
    srcActive[EN_LINE]  = lineFlag;
    srcActive[EN_MODEM] = |modemDelta;
    srcActive[EN_RXTO]  = toFlag;
  end

  assign srcLive    = srcActive & enMask;
  assign curPending = |srcLive;
  assign irq        = curPending;

  // Fixed priority selection
  always_comb begin
    if      (srcLive[EN_LINE]) curCode = SRC_LINE;
    else if (srcLive[EN_RXD])  curCode = SRC_RXD;
    else if (srcLive[EN_RXTO]) curCode = SRC_RXTO;
    else if (srcLive[EN_TXE])  curCode = SRC_TXE;
    else                       curCode = SRC_MODEM;
  end

  assign identVal = {{2{fifoOn}}, 2'b00, curCode, ~curPending};

  // R10: an enabled latched line error outranks everything
  p_line_first_r10: assert property (@(posedge clk) disable iff (!rstN)
    (lineFlag && enMask[EN_LINE]) |-> (curCode == SRC_LINE && !identVal[0]));

  // R5: outside FIFO mode a single entry is enough
  p_single_thresh_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoOn && rxLevel != '0 && enMask[EN_RXD] && !(lineFlag && enMask[EN_LINE]))
      |-> (curCode == SRC_RXD && !identVal[0]));

  // R8: reading the transmit code removes it on the next cycle
  p_tx_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrTx && !strobe.armTx) |=> !(curPending && curCode == SRC_TXE));

  // R7: a timeout pulse is always latched
  p_timeout_latch_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setTo |=> toFlag);

  // R11: no request without some enable
  p_irq_enabled_r11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (enMask != '0));

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LINE_W     = 4,
  parameter int MODEM_W    = 4,
  parameter int LEVEL_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [4:0]         enMask,
  input  logic               fifoOn,
  input  logic [1:0]         trigSel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [LINE_W-1:0]  lineErr,
  input  logic               lineClr,
  input  logic               rxTimeout,
  input  logic               timeoutClr,
  input  logic               txEmpty,
  input  logic [MODEM_W-1:0] modemDelta,
  input  logic               identRd,
  output logic               irq,
  output logic [7:0]         identVal
);

  irqStrobe_t strobe;
  srcCode_e   curCode;
  logic       curPending;

  uart_irq_ctrl #(.LINE_W(LINE_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .lineErr    (lineErr),
    .lineClr    (lineClr),
    .rxTimeout  (rxTimeout),
    .timeoutClr (timeoutClr),
    .txEmpty    (txEmpty),
    .identRd    (identRd),
    .curCode    (curCode),
    .curPending (curPending),
    .strobe     (strobe)
  );

  uart_irq_dpath #(.LEVEL_W(LEVEL_W), .MODEM_W(MODEM_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .enMask     (enMask),
    .fifoOn     (fifoOn),
    .trigSel    (trigSel),
    .rxLevel    (rxLevel),
    .txEmpty    (txEmpty),
    .modemDelta (modemDelta),
    .irq        (irq),
    .identVal   (identVal),
    .curCode    (curCode),
    .curPending (curPending)
  );

endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LEVEL_W    = 5;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [4:0]         enMask = '0;
  logic               fifoOn = 1'b0;
  logic [1:0]         trigSel = '0;
  logic [LEVEL_W-1:0] rxLevel = '0;
  logic [3:0]         lineErr = '0;
  logic               lineClr = 1'b0;
  logic               rxTimeout = 1'b0;
  logic               timeoutClr = 1'b0;
  logic               txEmpty = 1'b0;
  logic [3:0]         modemDelta = '0;
  logic               identRd = 1'b0;
  logic               irq;
  logic [7:0]         identVal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  uart_irq_ident dut_i (
    .clk(clk), .rstN(rstN), .enMask(enMask), .fifoOn(fifoOn), .trigSel(trigSel),
    .rxLevel(rxLevel), .lineErr(lineErr), .lineClr(lineClr), .rxTimeout(rxTimeout),
    .timeoutClr(timeoutClr), .txEmpty(txEmpty), .modemDelta(modemDelta),
    .identRd(identRd), .irq(irq), .identVal(identVal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Expected byte from the requirements (act bits follow the enable positions)
  function automatic logic [7:0] expIdent(input logic fifo, input logic [4:0] en,
                                          input logic [4:0] act);
    logic [4:0] live;
    logic [2:0] code;
    logic       pend;
    live = en & act;
    pend = 1'b1;
    if      (live[2]) code = 3'd3;
    else if (live[0]) code = 3'd2;
    else if (live[4]) code = 3'd6;
    else if (live[1]) code = 3'd1;
    else if (live[3]) code = 3'd0;
    else begin code = 3'd0; pend = 1'b0; end
    return {fifo ? 2'b11 : 2'b00, 2'b00, code, ~pend};
  endfunction

  function automatic int expThresh(input logic fifo, input logic [1:0] sel);
    if (!fifo) return 1;
    if (sel == 2'd0) return 1;
    if (sel == 2'd3) return 15;
    return 4 * int'(sel);
  endfunction

  task automatic chk(input logic [7:0] exp, input string tag);
    total++;
    if (identVal !== exp || irq !== ~exp[0]) begin
      bad++;
      $display("FAIL %s: ident=%02h irq=%b expected ident=%02h irq=%b",
               tag, identVal, irq, exp, ~exp[0]);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clearSticky();
    lineClr = 1'b1; timeoutClr = 1'b1;
    tick();
    lineClr = 1'b0; timeoutClr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick();
    chk(8'h01, "R1 reset value");

    // R4 R5 R3: threshold sweep, only received data enabled
    enMask = 5'b00001;
    for (int f = 0; f < 2; f++) begin
      for (int s = 0; s < 4; s++) begin
        for (int l = 0; l <= 16; l++) begin
          fifoOn = f[0]; trigSel = s[1:0]; rxLevel = l[LEVEL_W-1:0];
          #1;
          chk(expIdent(f[0], 5'b00001, {4'b0, (l >= expThresh(f[0], s[1:0]))}),
              f ? "R4 R3 fifo threshold" : "R5 R3 single threshold");
        end
      end
    end

    // R2 R6 R7 R8 R9 R10 R11: every source combination under every enable mask
    trigSel = 2'd0;
    for (int a = 0; a < 32; a++) begin
      enMask = '0;
      clearSticky();
      fifoOn     = a[0] ^ a[3];
      lineErr    = a[2] ? 4'b0010 : 4'b0000;
      rxTimeout  = a[4];
      rxLevel    = a[0] ? 5'd3 : 5'd0;
      txEmpty    = a[1];
      modemDelta = a[3] ? 4'b0100 : 4'b0000;
      tick();
      lineErr = '0; rxTimeout = 1'b0;
      for (int e = 0; e < 32; e++) begin
        enMask = e[4:0];
        #1;
        chk(expIdent(fifoOn, e[4:0], a[4:0]), "R10 R11 R2 priority/enable");
      end
    end

    // R6: set wins over clear, latch holds, clear removes it
    enMask = 5'b00100; fifoOn = 1'b0; rxLevel = '0; modemDelta = '0; txEmpty = 1'b0;
    clearSticky();
    chk(8'h01, "R6 idle after clear");
    lineErr = 4'b1000; lineClr = 1'b1;
    tick();
    lineErr = '0; lineClr = 1'b0;
    chk(8'h06, "R6 set beats clear");
    tick(); tick();
    chk(8'h06, "R6 latch holds");
    lineClr = 1'b1;
    tick();
    lineClr = 1'b0;
    chk(8'h01, "R6 cleared");

    // R7: timeout latch and clear
    enMask = 5'b10000; fifoOn = 1'b1;
    rxTimeout = 1'b1;
    tick();
    rxTimeout = 1'b0;
    chk(8'hCC, "R7 timeout code");
    tick(); tick();
    chk(8'hCC, "R7 timeout held");
    timeoutClr = 1'b1;
    tick();
    timeoutClr = 1'b0;
    chk(8'hC1, "R7 timeout cleared");

    // R8: read of the transmit code disarms until the next empty edge
    enMask = 5'b00010; fifoOn = 1'b0;
    txEmpty = 1'b1;
    tick();
    chk(8'h02, "R8 armed transmit");
    identRd = 1'b1;
    tick();
    identRd = 1'b0;
    chk(8'h01, "R8 disarmed by read");
    tick(); tick();
    chk(8'h01, "R8 stays disarmed while empty");
    txEmpty = 1'b0;
    tick();
    txEmpty = 1'b1;
    tick();
    chk(8'h02, "R8 rearmed on empty edge");

    // R8: a read returning another code leaves the transmit source armed
    enMask = 5'b00110;
    lineErr = 4'b0001;
    tick();
    lineErr = '0;
    chk(8'h06, "R8 R10 line above transmit");
    identRd = 1'b1;
    tick();
    identRd = 1'b0;
    lineClr = 1'b1;
    tick();
    lineClr = 1'b0;
    chk(8'h02, "R8 transmit survives other read");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule